// File: doc/BRIEF.md
# Split-Transaction Read Controller

This block sits on the memory side of a shared bus and serves reads as split transactions. A requester presents a read with an address and a tag for one cycle, and the block answers in that same cycle. It either accepts the read or refuses it with a retry. After that cycle the bus is free for other traffic. Each accepted read goes to a synchronous memory at once and waits in an ordered queue for a programmed latency.

When the read at the head of the queue has waited long enough, the block raises its bus request and waits for the external arbiter. In the cycle it sees the grant, it drives the returned data together with the requester's unchanged tag. Several reads can be outstanding at once, so reads are pipelined over the bus.

Each queue entry runs its own small state machine with three states:
- SLOT_FREE, the entry is empty.
- SLOT_WAIT, the entry is counting down its latency.
- SLOT_DONE, the data is ready and waiting for the bus.

The transitions are LOAD (SLOT_FREE to SLOT_WAIT, or straight to SLOT_DONE when the latency is 1), EXPIRE (SLOT_WAIT to SLOT_DONE) and DELIVER (SLOT_DONE to SLOT_FREE). A ring of read and write pointers with an occupancy count keeps the entries in request order.

Top module: `split_read_ctrl`

## Requirements
- R1: While reset is held and right after it, `bus_req` and `rsp_valid` are 0 and the queue is empty.
- R2: A request (`rq_valid`=1) is accepted in the same cycle (`rq_accept`=1) whenever fewer than DEPTH reads are outstanding. In that cycle `mem_rd_en`=1 and `mem_addr` equals `rq_addr`. The memory returns `mem_rd_data` in the following cycle.
- R3: When DEPTH reads are outstanding, a request gets `rq_retry`=1, `rq_accept`=0 and `mem_rd_en`=0. It leaves no trace in the later responses.
- R4: A read accepted in cycle n becomes ready in cycle n+LAT. `bus_req` is 1 in exactly those cycles where the oldest outstanding read is ready.
- R5: `rsp_valid` is 1 only in a cycle where both `bus_req` and `bus_gnt` are 1. `rsp_tag` then equals the tag given with that read, and `rsp_data` equals the memory data for its address.
- R6: Responses leave in the order their requests were accepted, whatever the grant pattern.
- R7: Without a grant, `bus_req` stays at 1 and the head read is kept. A refused grant loses no read.
- R8: Reads are pipelined. Up to DEPTH reads may be outstanding, and ready reads are delivered on consecutive cycles while the grant stays high.
- R9: When `rsp_valid` is 0, `rsp_tag` and `rsp_data` are driven to 0, and `bus_gnt` has no effect on the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rq_valid | input | 1 | Read request present this cycle |
| rq_addr | input | AW | Read address |
| rq_tag | input | TW | Requester tag |
| rq_accept | output | 1 | Request taken into the queue |
| rq_retry | output | 1 | Request refused, queue full |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_rd_data | input | DW | Memory data, one cycle after the strobe |
| bus_req | output | 1 | Bus mastership request for the response phase |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| rsp_valid | output | 1 | Response driven on the bus this cycle |
| rsp_tag | output | TW | Tag of the returned read |
| rsp_data | output | DW | Returned read data |

## Verification
The queue is tried with four patterns:
- A lone read under a long withheld grant. This separates the latency count from the bus hold behaviour.
- A burst past capacity with no grant. This shows that retries leave the queue intact.
- A drain under a steady grant. This separates true back-to-back delivery from one response per two cycles.
- A long mixed stream with interleaved requests and a sparse, periodic grant. This exposes ordering or tag slips when pushes and pops meet in the same cycle.

Every cycle, all outputs are compared against a behavioural queue model.

// File: rtl/split_read_pkg.sv
package split_read_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_DONE = 2'd2
    } slot_state_e;

endpackage

// File: rtl/srd_slot.sv
module srd_slot
    import split_read_pkg::*;
#(
    parameter int DW  = 16,
    parameter int TW  = 4,
    parameter int LAT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] tag_i,
    input  logic [DW-1:0] mem_data_i,
    input  logic          deliver_i,
    output logic          done_o,
    output logic [TW-1:0] tag_o,
    output logic [DW-1:0] data_o
);
    localparam int CW = (LAT > 2) ? $clog2(LAT) : 1;

    slot_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          cap_q;
    logic [TW-1:0] tag_q;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: if (load_i)        state_d = (LAT == 1) ? SLOT_DONE : SLOT_WAIT;
            SLOT_WAIT: if (cnt_q == '0)   state_d = SLOT_DONE;
            SLOT_DONE: if (deliver_i)     state_d = SLOT_FREE;
            default:                      state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            cap_q  <= 1'b0;
            tag_q  <= '0;
            data_q <= '0;
        end else begin
            cap_q <= load_i;
            if (load_i) begin
                cnt_q <= (LAT > 2) ? CW'(LAT - 2) : '0;
                tag_q <= tag_i;
            end else if (state_q == SLOT_WAIT && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (cap_q) data_q <= mem_data_i;
        end
    end

    assign done_o = (state_q == SLOT_DONE);
    assign tag_o  = tag_q;
    assign data_o = cap_q ? mem_data_i : data_q;

endmodule

// File: rtl/srd_ring.sv
module srd_ring #(
    parameter int DEPTH = 4,
    parameter int PW    = 2,
    parameter int OW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    output logic [PW-1:0] wr_ptr_o,
    output logic [PW-1:0] rd_ptr_o,
    output logic [OW-1:0] occ_o,
    output logic          full_o
);
    logic [PW-1:0] wr_q, rd_q;
    logic [OW-1:0] occ_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            occ_q <= '0;
        end else begin
            if (push_i) wr_q <= bump(wr_q);
            if (pop_i)  rd_q <= bump(rd_q);
            unique case ({push_i, pop_i})
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end

    assign wr_ptr_o = wr_q;
    assign rd_ptr_o = rd_q;
    assign occ_o    = occ_q;
    assign full_o   = (occ_q == OW'(DEPTH));

endmodule

// File: rtl/split_read_ctrl.sv
module split_read_ctrl
    import split_read_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int TW    = 4,
    parameter int DEPTH = 4,
    parameter int LAT   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rq_valid,
    input  logic [AW-1:0] rq_addr,
    input  logic [TW-1:0] rq_tag,
    output logic          rq_accept,
    output logic          rq_retry,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rd_data,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          rsp_valid,
    output logic [TW-1:0] rsp_tag,
    output logic [DW-1:0] rsp_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OW = $clog2(DEPTH + 1);

    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [OW-1:0] occ;
    logic          full;
    logic          push, pop;

    logic [DEPTH-1:0] slot_done;
    logic [TW-1:0]    slot_tag  [DEPTH];
    logic [DW-1:0]    slot_data [DEPTH];

    assign push = rq_valid && !full;
    assign pop  = bus_req && bus_gnt;

    srd_ring #(.DEPTH(DEPTH), .PW(PW), .OW(OW)) ring_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (push),
        .pop_i    (pop),
        .wr_ptr_o (wr_ptr),
        .rd_ptr_o (rd_ptr),
        .occ_o    (occ),
        .full_o   (full)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        srd_slot #(.DW(DW), .TW(TW), .LAT(LAT)) slot_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (push && (wr_ptr == PW'(i))),
            .tag_i      (rq_tag),
            .mem_data_i (mem_rd_data),
            .deliver_i  (pop && (rd_ptr == PW'(i))),
            .done_o     (slot_done[i]),
            .tag_o      (slot_tag[i]),
            .data_o     (slot_data[i])
        );
    end

    always_comb begin
        rq_accept = push;
        rq_retry  = rq_valid && full;
        mem_rd_en = push;
        mem_addr  = push ? rq_addr : '0;
        bus_req   = (occ != '0) && slot_done[rd_ptr];
        rsp_valid = pop;
        rsp_tag   = pop ? slot_tag[rd_ptr]  : '0;
        rsp_data  = pop ? slot_data[rd_ptr] : '0;
    end

endmodule

// File: rtl/split_read_ctrl_chk.sv
module split_read_ctrl_chk #(
    parameter int DW    = 16,
    parameter int TW    = 4,
    parameter int DEPTH = 4,
    parameter int OW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rq_valid,
    input logic          rq_accept,
    input logic          rq_retry,
    input logic          mem_rd_en,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic          rsp_valid,
    input logic [TW-1:0] rsp_tag,
    input logic [DW-1:0] rsp_data,
    input logic [OW-1:0] occ
);
    assert_accept_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rq_accept |-> (mem_rd_en && rq_valid));

    assert_retry_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rq_retry |-> (!rq_accept && !mem_rd_en));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OW'(DEPTH));

    assert_full_then_retry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OW'(DEPTH) && rq_valid) |-> rq_retry);

    assert_rsp_needs_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (bus_req && bus_gnt));

    assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_tag == '0 && rsp_data == '0));

    assert_req_needs_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (occ != '0));
endmodule

bind split_read_ctrl split_read_ctrl_chk #(.DW(DW), .TW(TW), .DEPTH(DEPTH), .OW(OW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rq_valid  (rq_valid),
    .rq_accept (rq_accept),
    .rq_retry  (rq_retry),
    .mem_rd_en (mem_rd_en),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .rsp_valid (rsp_valid),
    .rsp_tag   (rsp_tag),
    .rsp_data  (rsp_data),
    .occ       (occ)
);

// File: tb/split_read_ctrl_tb_top.sv
`timescale 1ns/1ps
module split_read_ctrl_tb_top;
    localparam int AW = 8, DW = 16, TW = 4, DEPTH = 4, LAT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rq_valid = 1'b0;
    logic [AW-1:0] rq_addr = '0;
    logic [TW-1:0] rq_tag = '0;
    logic          rq_accept, rq_retry, mem_rd_en, bus_req, rsp_valid;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rd_data = '0;
    logic          bus_gnt = 1'b0;
    logic [TW-1:0] rsp_tag;
    logic [DW-1:0] rsp_data;

    always #4 clk = ~clk;

    split_read_ctrl #(.AW(AW), .DW(DW), .TW(TW), .DEPTH(DEPTH), .LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .rq_valid(rq_valid), .rq_addr(rq_addr), .rq_tag(rq_tag),
        .rq_accept(rq_accept), .rq_retry(rq_retry), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rd_data(mem_rd_data), .bus_req(bus_req), .bus_gnt(bus_gnt), .rsp_valid(rsp_valid),
        .rsp_tag(rsp_tag), .rsp_data(rsp_data)
    );

    function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
        return {a ^ 8'h5A, a + 8'd3};
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_fn(mem_addr);

    typedef struct { logic [TW-1:0] tag; logic [AW-1:0] addr; int acc; } ent_t;
    ent_t q[$];
    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s cycle=%0d actual=%0h expected=%0h", req, what, cyc, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [AW-1:0] a, input logic [TW-1:0] t, input bit g);
        bit full, acc, breq, rv;
        ent_t e;
        @(negedge clk);
        rq_valid = v; rq_addr = a; rq_tag = t; bus_gnt = g;
        #1;
        full = (q.size() == DEPTH);
        acc  = v && !full;
        breq = (q.size() > 0) && (cyc >= q[0].acc + LAT);
        rv   = breq && g;
        chk("R2", "rq_accept", rq_accept, acc);
        chk("R3", "rq_retry", rq_retry, v && full);
        chk("R2", "mem_rd_en", mem_rd_en, acc);
        if (acc) chk("R2", "mem_addr", mem_addr, a);
        chk("R4", "bus_req", bus_req, breq);
        chk("R5", "rsp_valid", rsp_valid, rv);
        if (rv) begin
            chk("R6", "rsp_tag", rsp_tag, q[0].tag);
            chk("R5", "rsp_data", rsp_data, mem_fn(q[0].addr));
        end else begin
            chk("R9", "rsp_tag idle", rsp_tag, 0);
            chk("R9", "rsp_data idle", rsp_data, 0);
        end
        if (rv) void'(q.pop_front());
        if (acc) begin e.tag = t; e.addr = a; e.acc = cyc; q.push_back(e); end
        cyc++;
    endtask

    initial begin
        #1600000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet during reset
        repeat (3) begin
            @(negedge clk); #1;
            chk("R1", "bus_req in reset", bus_req, 0);
            chk("R1", "rsp_valid in reset", rsp_valid, 0);
        end
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1", "bus_req after reset", bus_req, 0);
        chk("R1", "rq_retry after reset", rq_retry, 0);

        // R4 R7: one read, grant withheld long after it is ready
        step(1, 8'h21, 4'h5, 0);
        for (int k = 0; k < 12; k++) step(0, 0, 0, 0);
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);

        // R3: burst past capacity, no grant
        for (int k = 0; k < 7; k++) step(1, 8'h40 + 8'(k), 4'(k + 1), 0);
        for (int k = 0; k < 6; k++) step(0, 0, 0, 0);
        // R8: steady grant drains back to back
        for (int k = 0; k < 6; k++) step(0, 0, 0, 1);

        // R6 R8 R9: mixed traffic
        for (int k = 0; k < 300; k++)
            step((k % 3) != 0, 8'((k * 37) & 8'hFF), 4'(k), (k % 5) < 2);
        // R6: mixed traffic with steady grant and request every cycle
        for (int k = 0; k < 60; k++) step(1, 8'(k * 11), 4'(k + 3), 1);
        for (int k = 0; k < 20; k++) step(0, 0, 0, 1);
        chk("R8", "queue drained", q.size(), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule